// File: doc/BRIEF.md
# Sprite Graphics Serializer with Mirror Mode

This block turns one byte of sprite graphics into a stream of single-bit pixels for downstream video logic. The byte comes from a two-stage holding chain. A write places data in the front ("new") copy. A separate copy strobe moves the front copy into the back ("old") copy. A select input picks which of the two copies is shown. This lets software stage the next pattern while the current one is still on screen.

A start pulse opens an eight-pixel window. Each pixel enable advances a 3-bit binary counter by one step. In normal mode the counter's true value picks the pixel position, so bit 7 leaves first. In mirror mode the counter's bit-inverted value picks the position, so the same up-counter walks the byte in the opposite order and bit 0 leaves first. The mirror setting is captured when the start pulse arrives. Outside the window the output is held at zero.

Top module: `sprite_serializer`

## Requirements
- R1: A cycle with `gfx_load` high stores `gfx_wdata` in the front copy. A later sprite with `use_old` low shows that value.
- R2: A cycle with `gfx_copy` high moves the value the front copy held before that edge into the back copy. This is also true when `gfx_load` is high in the same cycle. Without `gfx_copy`, the back copy keeps its value.
- R3: While `use_old` is 1 the back copy feeds the output, and while it is 0 the front copy does.
- R4: With mirror off, the pixels leave in the order bit 7, bit 6, …, bit 0 of the selected byte.
- R5: With mirror on, the pixels leave in the order bit 0, bit 1, …, bit 7.
- R6: `mirror` is sampled only on the clock edge where `start` is high. Changing it during a sprite leaves that sprite's order unchanged.
- R7: After the edge that samples `start`, `pix_out` shows the first pixel. Each later edge with `pix_en` high moves on by one pixel. Edges with `pix_en` low hold the current pixel.
- R8: `pix_out` is 0 after reset. It is also 0 once the eighth pixel has been advanced past, and it stays 0 through further `pix_en` pulses until the next `start`.
- R9: A `start` during an active sprite restarts it from the first pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gfx_load | input | 1 | Write strobe for the front copy |
| gfx_wdata | input | W | Graphics byte to write |
| gfx_copy | input | 1 | Move the front copy into the back copy |
| mirror | input | 1 | Mirror mode request, sampled at start |
| use_old | input | 1 | 1 selects the back copy for display |
| start | input | 1 | Begin a new sprite |
| pix_en | input | 1 | Advance one pixel |
| pix_out | output | 1 | Serial pixel |

## Verification
`pix_out` is decoded without a register from the counter, the captured mirror bit and the selected copy. The first pixel therefore appears right after the clock edge that sees `start`, and pixel i appears after the i-th `pix_en` edge that follows. A new byte or a copy becomes visible one edge after its strobe. The bench drives every input on the falling edge and samples at the next falling edge, halfway between the edge that updates the state and the following one. This gives exactly one register stage between a stimulus and its check. Stall, restart and mid-sprite mirror changes are timed on that same falling-edge grid.

// File: rtl/sprite_serializer.sv
module sprite_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gfx_load,
  input  logic [W-1:0] gfx_wdata,
  input  logic         gfx_copy,
  input  logic         mirror,
  input  logic         use_old,
  input  logic         start,
  input  logic         pix_en,
  output logic         pix_out
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  new_q, old_q;
  logic [CW-1:0] cnt_q;
  logic          active_q, refl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_q <= '0;
      old_q <= '0;
    end else begin
      if (gfx_load) new_q <= gfx_wdata;
      if (gfx_copy) old_q <= new_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      refl_q   <= 1'b0;
    end else if (start) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
      refl_q   <= mirror;
    end else if (active_q && pix_en) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) active_q <= 1'b0;
    end
  end

  // Position 0 is the MSB; mirror uses the inverted counter outputs.
  logic [CW-1:0] pos;
  logic [W-1:0]  src;
  assign pos     = refl_q ? ~cnt_q : cnt_q;
  assign src     = use_old ? old_q : new_q;
  assign pix_out = active_q & src[LAST - pos];
endmodule

// File: rtl/sprite_serializer_chk.sv
module sprite_serializer_chk #(
  parameter int W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 gfx_load,
  input logic [W-1:0]         gfx_wdata,
  input logic                 gfx_copy,
  input logic                 start,
  input logic                 pix_en,
  input logic                 pix_out,
  input logic [W-1:0]         new_q,
  input logic [W-1:0]         old_q,
  input logic [$clog2(W)-1:0] cnt_q,
  input logic                 active_q,
  input logic                 refl_q
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  a_r1_load_front: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_load |=> new_q == $past(gfx_wdata));
  a_r2_copy_back: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_copy |=> old_q == $past(new_q));
  a_r2_back_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !gfx_copy |=> $stable(old_q));
  a_r6_mirror_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(refl_q));
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pix_en && !start && cnt_q != LAST) |=> (active_q && cnt_q == $past(cnt_q) + 1'b1));
  a_r7_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en && !start) |=> ($stable(cnt_q) && $stable(active_q)));
  a_r8_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pix_en && !start && cnt_q == LAST) |=> !active_q);
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !pix_out);
  a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active_q && cnt_q == '0));
endmodule

bind sprite_serializer sprite_serializer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gfx_load(gfx_load), .gfx_wdata(gfx_wdata),
  .gfx_copy(gfx_copy), .start(start), .pix_en(pix_en), .pix_out(pix_out),
  .new_q(new_q), .old_q(old_q), .cnt_q(cnt_q), .active_q(active_q), .refl_q(refl_q)
);

// File: tb/sprite_serializer_tb.sv
module sprite_serializer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gfx_load = 1'b0, gfx_copy = 1'b0, mirror = 1'b0, use_old = 1'b0;
  logic       start = 1'b0, pix_en = 1'b0;
  logic [7:0] gfx_wdata = '0;
  logic       pix_out;
  int         n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sprite_serializer #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .gfx_load(gfx_load), .gfx_wdata(gfx_wdata),
    .gfx_copy(gfx_copy), .mirror(mirror), .use_old(use_old), .start(start),
    .pix_en(pix_en), .pix_out(pix_out)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic write_gfx(input logic [7:0] d, input logic ld, input logic cp);
    @(negedge clk); gfx_wdata = d; gfx_load = ld; gfx_copy = cp;
    @(negedge clk); gfx_load = 1'b0; gfx_copy = 1'b0;
  endtask

  // First pixel lands in got[7]; flip_at toggles mirror after that pixel.
  task automatic run_sprite(input int flip_at, output logic [7:0] got);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; pix_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      got[7-i] = pix_out;
      if (i == flip_at) mirror = ~mirror;
      @(negedge clk);
    end
    pix_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R8 reset", {7'b0, pix_out}, 8'h00);
  endtask

  task automatic t_normal();
    logic [7:0] g;
    write_gfx(8'hCA, 1'b1, 1'b0);
    mirror = 1'b0; use_old = 1'b0;
    run_sprite(-1, g);
    check("R1/R4 normal order", g, 8'hCA);
    check("R8 zero after eighth pixel", {7'b0, pix_out}, 8'h00);
    write_gfx(8'h81, 1'b1, 1'b0);
    run_sprite(-1, g);
    check("R4 normal order 81", g, 8'h81);
  endtask

  task automatic t_mirror();
    logic [7:0] g;
    write_gfx(8'hCA, 1'b1, 1'b0);
    mirror = 1'b1;
    run_sprite(-1, g);
    check("R5 mirror order", g, rev8(8'hCA));
    mirror = 1'b0;
  endtask

  task automatic t_copy();
    logic [7:0] g;
    write_gfx(8'h3C, 1'b1, 1'b0);
    write_gfx(8'h00, 1'b0, 1'b1);
    write_gfx(8'hF0, 1'b1, 1'b0);
    use_old = 1'b1; run_sprite(-1, g);
    check("R2/R3 back copy shown", g, 8'h3C);
    use_old = 1'b0; run_sprite(-1, g);
    check("R3 front copy shown", g, 8'hF0);
    write_gfx(8'h0F, 1'b1, 1'b1);
    use_old = 1'b1; run_sprite(-1, g);
    check("R2 load+copy keeps prior front", g, 8'hF0);
    write_gfx(8'h99, 1'b1, 1'b0);
    run_sprite(-1, g);
    check("R2 back holds without copy", g, 8'hF0);
    use_old = 1'b0; run_sprite(-1, g);
    check("R1 new front value", g, 8'h99);
  endtask

  task automatic t_midflip();
    logic [7:0] g;
    write_gfx(8'hCA, 1'b1, 1'b0);
    mirror = 1'b0;
    run_sprite(3, g);
    check("R6 mirror change mid-sprite ignored", g, 8'hCA);
    mirror = 1'b0;
  endtask

  task automatic t_stall();
    logic p0;
    write_gfx(8'h80, 1'b1, 1'b0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    p0 = pix_out;
    check("R7 first pixel after start", {7'b0, p0}, 8'h01);
    repeat (3) @(negedge clk);
    check("R7 held while pix_en low", {7'b0, pix_out}, 8'h01);
    pix_en = 1'b1; @(negedge clk); pix_en = 1'b0;
    check("R7 one step per enable", {7'b0, pix_out}, 8'h00);
    @(negedge clk);
    check("R7 no step without enable", {7'b0, pix_out}, 8'h00);
  endtask

  task automatic t_restart();
    write_gfx(8'h80, 1'b1, 1'b0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; pix_en = 1'b1;
    repeat (3) @(negedge clk);
    pix_en = 1'b0;
    check("R9 mid-sprite before restart", {7'b0, pix_out}, 8'h00);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R9 restart shows first pixel", {7'b0, pix_out}, 8'h01);
  endtask

  task automatic t_idle();
    logic [7:0] g;
    write_gfx(8'hFF, 1'b1, 1'b0);
    run_sprite(-1, g);
    check("R4 all ones", g, 8'hFF);
    pix_en = 1'b1;
    repeat (4) @(negedge clk);
    pix_en = 1'b0;
    check("R8 idle after extra enables", {7'b0, pix_out}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_normal();
    t_mirror();
    t_copy();
    t_midflip();
    t_stall();
    t_restart();
    t_idle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule